// File: doc/BRIEF.md
# Floating-Point Unordered Compare Unit

This block compares two IEEE-754 binary64 operands and sorts their relationship into one of four outcomes: less, greater, equal or unordered. The outcome is written as a 4-bit condition field into one of several slots of a condition register. The slot is chosen by an index that arrives with the operands. The same outcome is also copied into a 5-bit class code, which a status register can read.

The compare is unordered. A NaN on either side gives the unordered outcome and nothing else. Only a signalling NaN raises the sticky invalid-operation flag, and a summary exception flag is raised along with it. Both flags stay set until the clear input is asserted. Operands are compared as full binary64 values, so single-precision values held in double format need no special handling.

The block has one register stage. A compare requested with `valid_i` updates the condition register, the class code and the flags on the next clock edge, and `done_o` pulses high for one cycle at the same time.

Top module: `fcu_top`

## Requirements
- R1: If either operand is a NaN (exponent all ones, fraction nonzero), the written field is 4'b1000: unordered set, and less, greater and equal cleared.
- R2: A signalling NaN (exponent all ones, fraction nonzero, fraction bit 51 = 0) on either operand sets `vx_snan_o`. A quiet NaN (fraction bit 51 = 1) leaves `vx_snan_o` and `fx_o` unchanged.
- R3: Inside a field, bit 0 means A<B, bit 1 means A>B, bit 2 means A==B and bit 3 means unordered. Every compare sets exactly one of these bits.
- R4: Positive zero and negative zero compare equal, in either order.
- R5: `class_o` is 5'b01000 for less, 5'b00100 for greater, 5'b00010 for equal and 5'b00001 for unordered. It holds its value until the next compare.
- R6: Slot k occupies `cr_o[4k+3:4k]`. A compare writes only the slot named by `slot_i`, and the other slots keep their values.
- R7: Non-NaN operands are ordered by value: a negative operand is below a positive one, magnitudes are ordered within a sign, and infinities sit above or below every finite value.
- R8: `vx_snan_o` and `fx_o` are sticky. `fx_o` is set when `vx_snan_o` rises. `clr_i` clears both, but a signalling-NaN compare in the same cycle as `clr_i` leaves both set.
- R9: All outputs are registered. A compare updates them on the clock edge that samples `valid_i`, and `done_o` is high for exactly that one following cycle. Without `valid_i`, `cr_o` and `class_o` do not change.
- R10: After reset, `cr_o`, `class_o`, `vx_snan_o`, `fx_o` and `done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Starts a compare of `op_a_i` against `op_b_i` |
| op_a_i | input | 64 | Operand A, binary64 |
| op_b_i | input | 64 | Operand B, binary64 |
| slot_i | input | 3 | Index of the condition-register slot to write |
| clr_i | input | 1 | Clears the sticky flags |
| cr_o | output | 32 | Condition register, eight 4-bit slots |
| class_o | output | 5 | Class code of the last compare |
| vx_snan_o | output | 1 | Sticky flag for an invalid operation caused by a signalling NaN |
| fx_o | output | 1 | Sticky summary exception flag |
| done_o | output | 1 | One-cycle pulse when a compare's results are valid |

## Verification
The bench builds the block with its default parameters: 64-bit operands, an 11-bit exponent and eight slots. At this size the real binary64 corner values can be used directly: both zeros, the smallest subnormal, the largest finite value, both infinities, and quiet and signalling NaNs. It writes to all eight slot indices, and each write can be checked against the seven slots it must leave alone. With one-cycle registering, each compare's outcome, the flag set and clear, and the simultaneous clear-and-set case can each be checked in a single exact cycle.

// File: rtl/fcu_pkg.sv
// Package fcu_pkg
// Shared constants and types for the unordered compare unit.
// Assumes the standard condition-field layout, with four outcome bits.
package fcu_pkg;
    localparam int FIELD_W = 4;
    localparam int CLASS_W = 5;

    // Bit positions inside one condition field
    localparam int F_LT = 0;
    localparam int F_GT = 1;
    localparam int F_EQ = 2;
    localparam int F_UN = 3;

    // Per-operand classification flags
    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_nan;
        logic is_snan;
    } opnd_flags_t;
endpackage

// File: rtl/fcu_classify.sv
// Module fcu_classify
// Splits one IEEE-754 operand into sign, magnitude and class flags.
// Assumes a hidden-bit format: sign MSB, then EXP_W exponent bits, then fraction.
// The fraction MSB tells a quiet NaN (1) from a signalling NaN (0).
module fcu_classify #(
    parameter int DATA_W = 64,
    parameter int EXP_W  = 11
) (
    input  logic [DATA_W-1:0]    op_i,
    output fcu_pkg::opnd_flags_t flags_o,
    output logic [DATA_W-2:0]    mag_o
);
    localparam int FRAC_W = DATA_W - 1 - EXP_W;

    logic [EXP_W-1:0]  exp_w;
    logic [FRAC_W-1:0] frac_w;
    logic              exp_ones;

    // Purpose: split the operand and derive its class flags
    always_comb begin
        exp_w            = op_i[DATA_W-2 -: EXP_W];
        frac_w           = op_i[FRAC_W-1:0];
        exp_ones         = &exp_w;
        mag_o            = op_i[DATA_W-2:0];
        flags_o.sign     = op_i[DATA_W-1];
        flags_o.is_zero  = (op_i[DATA_W-2:0] == '0);
        flags_o.is_nan   = exp_ones && (frac_w != '0);
        flags_o.is_snan  = exp_ones && (frac_w != '0) && !frac_w[FRAC_W-1];
    end
endmodule

// File: rtl/fcu_order.sv
// Module fcu_order
// Sorts two classified operands into one condition field (one-hot).
// Assumes the magnitude field is exponent followed by fraction, so an
// unsigned compare of it orders values within a sign, infinities included.
module fcu_order #(
    parameter int MAG_W = 63
) (
    input  fcu_pkg::opnd_flags_t      fa_i,
    input  fcu_pkg::opnd_flags_t      fb_i,
    input  logic [MAG_W-1:0]          ma_i,
    input  logic [MAG_W-1:0]          mb_i,
    output logic [fcu_pkg::FIELD_W-1:0] field_o
);
    import fcu_pkg::*;

    logic a_mag_lt;
    logic mag_eq;

    // Purpose: pick exactly one outcome bit from signs and magnitudes
    always_comb begin
        a_mag_lt = (ma_i < mb_i);
        mag_eq   = (ma_i == mb_i);
        field_o  = '0;
        if (fa_i.is_nan || fb_i.is_nan) begin
            field_o[F_UN] = 1'b1;
        end else if (fa_i.is_zero && fb_i.is_zero) begin
            field_o[F_EQ] = 1'b1;
        end else if (fa_i.sign != fb_i.sign) begin
            if (fa_i.sign) field_o[F_LT] = 1'b1;
            else           field_o[F_GT] = 1'b1;
        end else if (mag_eq) begin
            field_o[F_EQ] = 1'b1;
        end else if (!fa_i.sign) begin
            if (a_mag_lt) field_o[F_LT] = 1'b1;
            else          field_o[F_GT] = 1'b1;
        end else begin
            if (a_mag_lt) field_o[F_GT] = 1'b1;
            else          field_o[F_LT] = 1'b1;
        end
    end
endmodule

// File: rtl/fcu_crfile.sv
// Module fcu_crfile
// Holds the condition register as SLOTS fields of FIELD_W bits.
// On a write, only the indexed slot is loaded and the others hold.
module fcu_crfile #(
    parameter int SLOTS = 8,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_i,
    input  logic [IDX_W-1:0]                    idx_i,
    input  logic [fcu_pkg::FIELD_W-1:0]         field_i,
    output logic [SLOTS*fcu_pkg::FIELD_W-1:0]   cr_o
);
    import fcu_pkg::*;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [FIELD_W-1:0] slot_q;
        logic               hit;

        // Purpose: decode whether this slot is the write target
        always_comb hit = wr_i && (idx_i == IDX_W'(k));

        // Purpose: load or hold this slot
        always_ff @(posedge clk) begin
            if (!rst_n)   slot_q <= '0;
            else if (hit) slot_q <= field_i;
        end

        assign cr_o[k*FIELD_W +: FIELD_W] = slot_q;
    end
endmodule

// File: rtl/fcu_status.sv
// Module fcu_status
// Keeps the class-code mirror, the sticky invalid-SNaN flag, the sticky
// summary flag and the done pulse. A clear in the same cycle as a new
// signalling NaN is overridden, so the flags end up set.
module fcu_status (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        valid_i,
    input  logic                        snan_hit_i,
    input  logic                        clr_i,
    input  logic [fcu_pkg::FIELD_W-1:0] field_i,
    output logic [fcu_pkg::CLASS_W-1:0] class_o,
    output logic                        vx_snan_o,
    output logic                        fx_o,
    output logic                        done_o
);
    import fcu_pkg::*;

    logic [CLASS_W-1:0] class_d;
    logic               snan_base;
    logic               fx_base;
    logic               hit;

    // Purpose: map the field onto the class code (less, greater, equal, unordered)
    always_comb begin
        class_d    = '0;
        class_d[3] = field_i[F_LT];
        class_d[2] = field_i[F_GT];
        class_d[1] = field_i[F_EQ];
        class_d[0] = field_i[F_UN];
    end

    // Purpose: apply the clear first, then any new signalling NaN
    always_comb begin
        snan_base = clr_i ? 1'b0 : vx_snan_o;
        fx_base   = clr_i ? 1'b0 : fx_o;
        hit       = valid_i && snan_hit_i;
    end

    // Purpose: register the class code and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            class_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= valid_i;
            if (valid_i) class_o <= class_d;
        end
    end

    // Purpose: sticky flags; the summary flag is set when the SNaN flag rises
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vx_snan_o <= 1'b0;
            fx_o      <= 1'b0;
        end else begin
            vx_snan_o <= snan_base | hit;
            fx_o      <= fx_base | (hit & ~snan_base);
        end
    end
endmodule

// File: rtl/fcu_top.sv
// Module fcu_top
// Unordered floating-point compare unit. Classifies both operands,
// orders them, writes the one-hot result into the selected condition slot
// and mirrors it into the class code. Results are valid one cycle after valid_i.
module fcu_top #(
    parameter int DATA_W = 64,
    parameter int EXP_W  = 11,
    parameter int SLOTS  = 8,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CR_W  = SLOTS * fcu_pkg::FIELD_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        valid_i,
    input  logic [DATA_W-1:0]           op_a_i,
    input  logic [DATA_W-1:0]           op_b_i,
    input  logic [IDX_W-1:0]            slot_i,
    input  logic                        clr_i,
    output logic [CR_W-1:0]             cr_o,
    output logic [fcu_pkg::CLASS_W-1:0] class_o,
    output logic                        vx_snan_o,
    output logic                        fx_o,
    output logic                        done_o
);
    import fcu_pkg::*;

    localparam int MAG_W = DATA_W - 1;

    opnd_flags_t        fa, fb;
    logic [MAG_W-1:0]   ma, mb;
    logic [FIELD_W-1:0] field;
    logic               snan_any;

    fcu_classify #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_cls_a (
        .op_i(op_a_i), .flags_o(fa), .mag_o(ma)
    );

    fcu_classify #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_cls_b (
        .op_i(op_b_i), .flags_o(fb), .mag_o(mb)
    );

    fcu_order #(.MAG_W(MAG_W)) u_order (
        .fa_i(fa), .fb_i(fb), .ma_i(ma), .mb_i(mb), .field_o(field)
    );

    // Purpose: a signalling NaN on either side raises the invalid flag
    always_comb snan_any = fa.is_snan || fb.is_snan;

    fcu_crfile #(.SLOTS(SLOTS)) u_cr (
        .clk(clk), .rst_n(rst_n), .wr_i(valid_i), .idx_i(slot_i),
        .field_i(field), .cr_o(cr_o)
    );

    fcu_status u_stat (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .snan_hit_i(snan_any),
        .clr_i(clr_i), .field_i(field), .class_o(class_o),
        .vx_snan_o(vx_snan_o), .fx_o(fx_o), .done_o(done_o)
    );
endmodule

// File: rtl/fcu_checker.sv
// Module fcu_checker
// Port-level properties of fcu_top, attached with bind.
module fcu_checker #(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CR_W  = SLOTS * 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [IDX_W-1:0] slot_i,
    input logic             clr_i,
    input logic [CR_W-1:0]  cr_o,
    input logic [4:0]       class_o,
    input logic             vx_snan_o,
    input logic             fx_o,
    input logic             done_o
);
    logic [IDX_W-1:0] slot_q;
    logic [3:0]       wr_field;

    // Purpose: remember which slot the last request targeted
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_i;
    end

    // Purpose: pick out the slot just written
    always_comb wr_field = cr_o[{slot_q, 2'b00} +: 4];

    p_done_after_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !done_o);
    p_cr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(cr_o) && $stable(class_o));
    p_field_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $countones(wr_field) == 1);
    p_class_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> class_o == {1'b0, wr_field[0], wr_field[1], wr_field[2], wr_field[3]});
    p_snan_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vx_snan_o && !clr_i) |=> vx_snan_o);
    p_fx_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vx_snan_o) |-> fx_o);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !valid_i) |=> !vx_snan_o && !fx_o);
endmodule

bind fcu_top fcu_checker #(.SLOTS(SLOTS)) u_fcu_chk (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .slot_i(slot_i),
    .clr_i(clr_i), .cr_o(cr_o), .class_o(class_o), .vx_snan_o(vx_snan_o),
    .fx_o(fx_o), .done_o(done_o)
);

// File: tb/fcu_top_test.sv
module fcu_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [63:0] op_a_i = '0;
    logic [63:0] op_b_i = '0;
    logic [2:0]  slot_i = '0;
    logic        clr_i = 1'b0;
    logic [31:0] cr_o;
    logic [4:0]  class_o;
    logic        vx_snan_o, fx_o, done_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_cr = '0;
    logic        exp_snan = 1'b0;
    logic        exp_fx = 1'b0;
    bit          finished = 0;

    localparam logic [63:0] P_ONE  = 64'h3FF0000000000000;
    localparam logic [63:0] P_TWO  = 64'h4000000000000000;
    localparam logic [63:0] N_ONE  = 64'hBFF0000000000000;
    localparam logic [63:0] N_THR  = 64'hC008000000000000;
    localparam logic [63:0] P_ZERO = 64'h0000000000000000;
    localparam logic [63:0] N_ZERO = 64'h8000000000000000;
    localparam logic [63:0] P_INF  = 64'h7FF0000000000000;
    localparam logic [63:0] N_INF  = 64'hFFF0000000000000;
    localparam logic [63:0] P_MAX  = 64'h7FEFFFFFFFFFFFFF;
    localparam logic [63:0] P_DEN  = 64'h0000000000000001;
    localparam logic [63:0] Q_NAN  = 64'h7FF8000000000000;
    localparam logic [63:0] S_NAN  = 64'h7FF0000000000001;
    localparam logic [63:0] P_1P5  = 64'h3FF8000000000000;

    fcu_top uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_a_i(op_a_i),
        .op_b_i(op_b_i), .slot_i(slot_i), .clr_i(clr_i), .cr_o(cr_o),
        .class_o(class_o), .vx_snan_o(vx_snan_o), .fx_o(fx_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit is_nan(input logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    endfunction

    function automatic bit is_snan(input logic [63:0] x);
        return is_nan(x) && !x[51];
    endfunction

    // Reference outcome from real-number comparison
    function automatic logic [3:0] ref_field(input logic [63:0] a, input logic [63:0] b);
        real ra, rb;
        if (is_nan(a) || is_nan(b)) return 4'b1000;
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        if (ra < rb) return 4'b0001;
        if (ra > rb) return 4'b0010;
        return 4'b0100;
    endfunction

    function automatic logic [4:0] ref_class(input logic [3:0] f);
        case (f)
            4'b0001: return 5'b01000;
            4'b0010: return 5'b00100;
            4'b0100: return 5'b00010;
            default: return 5'b00001;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One compare; checks all outputs in the cycle after the request
    task automatic do_cmp(input logic [63:0] a, input logic [63:0] b,
                          input logic [2:0] s, input logic clr, input string req);
        logic [3:0] f;
        f = ref_field(a, b);
        @(negedge clk);
        op_a_i = a; op_b_i = b; slot_i = s; valid_i = 1'b1; clr_i = clr;
        if (clr) begin exp_snan = 1'b0; exp_fx = 1'b0; end
        if (is_snan(a) || is_snan(b)) begin
            if (!exp_snan) exp_fx = 1'b1;
            exp_snan = 1'b1;
        end
        exp_cr[s*4 +: 4] = f;
        @(negedge clk);
        valid_i = 1'b0; clr_i = 1'b0;
        check({req, " field"}, 64'(cr_o[s*4 +: 4]), 64'(f));
        check({req, " cr"}, 64'(cr_o), 64'(exp_cr));
        check({req, " class R5"}, 64'(class_o), 64'(ref_class(f)));
        check({req, " vx_snan R2"}, 64'(vx_snan_o), 64'(exp_snan));
        check({req, " fx R8"}, 64'(fx_o), 64'(exp_fx));
        check({req, " done R9"}, 64'(done_o), 64'd1);
    endtask

    task automatic t_reset();
        check("R10 cr", 64'(cr_o), 64'd0);
        check("R10 class", 64'(class_o), 64'd0);
        check("R10 flags", 64'({vx_snan_o, fx_o, done_o}), 64'd0);
    endtask

    task automatic t_ordering();
        do_cmp(P_ONE, P_TWO, 3'd0, 1'b0, "R7 pos less");
        do_cmp(N_ONE, N_THR, 3'd1, 1'b0, "R7 neg greater");
        do_cmp(P_TWO, P_TWO, 3'd2, 1'b0, "R3 equal");
        do_cmp(N_THR, P_DEN, 3'd3, 1'b0, "R7 mixed sign");
        do_cmp(P_INF, P_MAX, 3'd4, 1'b0, "R7 inf above max");
        do_cmp(N_INF, N_THR, 3'd5, 1'b0, "R7 neg inf");
        do_cmp(P_1P5, P_ONE, 3'd6, 1'b0, "R7 single in double");
    endtask

    task automatic t_zeros();
        do_cmp(P_ZERO, N_ZERO, 3'd7, 1'b0, "R4 +0 vs -0");
        do_cmp(N_ZERO, P_ZERO, 3'd7, 1'b0, "R4 -0 vs +0");
        do_cmp(N_ZERO, P_DEN, 3'd7, 1'b0, "R4 -0 vs denorm");
    endtask

    task automatic t_quiet_nan();
        do_cmp(Q_NAN, P_ONE, 3'd2, 1'b0, "R1 qnan a");
        do_cmp(N_INF, Q_NAN, 3'd3, 1'b0, "R1 qnan b");
        check("R2 qnan no flag", 64'(vx_snan_o), 64'd0);
    endtask

    task automatic t_signal_nan();
        do_cmp(P_ONE, S_NAN, 3'd1, 1'b0, "R2 snan b");
        do_cmp(P_ONE, P_TWO, 3'd1, 1'b0, "R8 sticky hold");
        do_cmp(S_NAN, S_NAN, 3'd0, 1'b0, "R2 snan again");
    endtask

    task automatic t_clear();
        @(negedge clk);
        clr_i = 1'b1;
        exp_snan = 1'b0; exp_fx = 1'b0;
        @(negedge clk);
        clr_i = 1'b0;
        check("R8 clear snan", 64'(vx_snan_o), 64'd0);
        check("R8 clear fx", 64'(fx_o), 64'd0);
        check("R9 no done on clear", 64'(done_o), 64'd0);
        check("R9 cr kept on clear", 64'(cr_o), 64'(exp_cr));
        do_cmp(S_NAN, P_ONE, 3'd4, 1'b1, "R8 clear with snan");
        check("R8 clear with snan flag", 64'(vx_snan_o), 64'd1);
    endtask

    task automatic t_slots();
        for (int k = 0; k < 8; k++) begin
            do_cmp((k % 2) ? P_TWO : N_ONE, P_ONE, 3'(k), 1'b0, "R6 slot walk");
        end
    endtask

    task automatic t_idle();
        logic [31:0] cr_snap;
        logic [4:0]  cl_snap;
        @(negedge clk);
        cr_snap = cr_o; cl_snap = class_o;
        op_a_i = Q_NAN; op_b_i = S_NAN; slot_i = 3'd5;
        repeat (3) @(negedge clk);
        check("R9 idle cr", 64'(cr_o), 64'(cr_snap));
        check("R9 idle class", 64'(class_o), 64'(cl_snap));
        check("R9 idle done", 64'(done_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ordering();
        t_zeros();
        t_quiet_nan();
        t_signal_nan();
        t_clear();
        t_slots();
        t_idle();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule